// File: doc/BRIEF.md
# Threshold-Signalling Receive Packet FIFO

This block is a single-clock receive buffer between a link layer and a user read port. Each stored word carries a data field and two markers, one for start of packet and one for end of packet. The block gives the reader two hints. The first says a burst is worth fetching, because the fill level is above a programmable low threshold. The second says at least one whole packet is held, which supports store-and-forward reading. The block also raises a pause request toward the link partner when the fill level passes a programmable high threshold. The words that arrive after the pause request fill the space above that high threshold.

The reader never needs to test for empty. A read enable may stay high, and each returned word is qualified by a valid flag one cycle later. A read on an empty buffer has no effect. A write to a full buffer is dropped and latches a sticky overflow flag. The depth must be at least one maximum-size packet, and a configuration that breaks this fails elaboration.

Top module: `rx_pkt_fifo`

## Requirements
- R1: A synchronous active-high `rst` empties the buffer and clears the packet count. While it is held and after it is released, `rd_valid`, `burst_avail`, `pkt_avail`, `pause_req` and `ovf_flag` are 0.
- R2: `burst_avail` is 1 exactly when the number of stored words is strictly greater than `lo_thresh`. It follows the fill level in the same cycle in which the level changes.
- R3: A read enable while the buffer is empty does not move the read side and does not change stored data. In the next cycle it returns `rd_valid` = 0.
- R4: A read enable on a non-empty buffer returns the oldest stored word on `rd_data`, with `rd_valid` = 1, in the cycle after the enable. Words leave in the order they were written.
- R5: `pkt_avail` is 1 exactly when at least one stored word has its end marker set. The count of such words rises on an accepted write with `wr_eop` = 1 and falls on an accepted read of a word with the end marker. When both happen in one cycle, the count is unchanged.
- R6: `pause_req` rises in the cycle in which the fill level becomes greater than `hi_thresh`. It falls only in the cycle in which the level becomes less than or equal to `lo_thresh`. Between the two thresholds it holds its value. The thresholds must satisfy `lo_thresh` < `hi_thresh` and must be stable outside reset.
- R7: A write enable while the buffer holds DEPTH words is dropped and leaves the stored words unchanged. It sets `ovf_flag`, which stays set until a cycle with `ovf_clear` = 1 and no new overflow. A new overflow wins over a clear in the same cycle.
- R8: The start and end markers written with a word come out on `rd_sop` and `rd_eop` together with that word.
- R9: DEPTH must be a power of two and at least MAX_PKT. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lo_thresh | input | AW+1 | Low threshold for burst hint and pause release |
| hi_thresh | input | AW+1 | High threshold for pause request |
| wr_en | input | 1 | Write enable from the link layer |
| wr_data | input | DATA_W | Word to store |
| wr_sop | input | 1 | Start-of-packet marker of the written word |
| wr_eop | input | 1 | End-of-packet marker of the written word |
| rd_en | input | 1 | Read enable, may stay high |
| rd_data | output | DATA_W | Word returned one cycle after an accepted read |
| rd_sop | output | 1 | Start marker of the returned word |
| rd_eop | output | 1 | End marker of the returned word |
| rd_valid | output | 1 | Qualifies `rd_data`, `rd_sop` and `rd_eop` |
| burst_avail | output | 1 | Fill level above `lo_thresh` |
| pkt_avail | output | 1 | At least one complete packet is stored |
| pause_req | output | 1 | Flow-control pause request, with hysteresis |
| ovf_clear | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky flag for a dropped write |

## Verification
A wrong fill count shows in the same cycle as a wrong `burst_avail` at some threshold setting. Sweeping `lo_thresh` across its whole range at every fill level therefore exposes an off-by-one at once. A bad read pointer, or an underflow that moves it, shows one cycle later as a wrong word, a lost marker or a valid flag on an empty read. A drifting end-of-packet count shows in `pkt_avail` as soon as the last stored end marker is read out.

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 16,
  parameter int MAX_PKT = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW:0]       lo_thresh,
  input  logic [AW:0]       hi_thresh,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sop,
  output logic              rd_eop,
  output logic              rd_valid,
  output logic              burst_avail,
  output logic              pkt_avail,
  output logic              pause_req,
  input  logic              ovf_clear,
  output logic              ovf_flag
);
  localparam int W = DATA_W + 2;

  // R9: store-and-forward needs room for one whole packet
  if (MAX_PKT > DEPTH || (1 << AW) != DEPTH) begin : g_bad_cfg
    $error("rx_pkt_fifo: DEPTH must be a power of two and >= MAX_PKT (R9)");
  end

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count, count_nxt, eop_cnt;

  wire full   = (count == (AW+1)'(DEPTH));
  wire wr_ok  = wr_en && !full;
  wire rd_ok  = rd_en && (count != '0);
  wire [W-1:0] head = mem[rp];
  wire head_eop = head[DATA_W];

  assign count_nxt   = count + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
  assign burst_avail = count > lo_thresh;
  assign pkt_avail   = eop_cnt != '0;

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= {wr_sop, wr_eop, wr_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      count     <= '0;
      eop_cnt   <= '0;
      rd_valid  <= 1'b0;
      pause_req <= 1'b0;
      ovf_flag  <= 1'b0;
      rd_data   <= '0;
      rd_sop    <= 1'b0;
      rd_eop    <= 1'b0;
    end else begin
      count    <= count_nxt;
      rd_valid <= rd_ok;
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) begin
        rp <= rp + 1'b1;
        {rd_sop, rd_eop, rd_data} <= head;
      end
      case ({wr_ok && wr_eop, rd_ok && head_eop})
        2'b10:   eop_cnt <= eop_cnt + 1'b1;
        2'b01:   eop_cnt <= eop_cnt - 1'b1;
        default: eop_cnt <= eop_cnt;
      endcase
      if (count_nxt > hi_thresh)       pause_req <= 1'b1;
      else if (count_nxt <= lo_thresh) pause_req <= 1'b0;
      if (wr_en && full)  ovf_flag <= 1'b1;
      else if (ovf_clear) ovf_flag <= 1'b0;
    end
  end

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (count == (AW+1)'(DEPTH)) && ovf_flag);
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clear) |=> ovf_flag);
  assert_empty_read_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && count == '0) |=> !rd_valid && $stable(rp));
  assert_read_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && count != '0) |=> rd_valid);
  assert_pkt_held_R5: assert property (@(posedge clk) disable iff (rst)
    eop_cnt <= count);
  assert_pause_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(pause_req) |-> count > hi_thresh);
  assert_pause_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(pause_req) |-> count <= lo_thresh);
endmodule

// File: tb/rx_pkt_fifo_bench.sv
module rx_pkt_fifo_bench;
  localparam int DW = 8, DEPTH = 8, AW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW:0] lo_thresh = '0, hi_thresh = 4'd7;
  logic wr_en = 0, wr_sop = 0, wr_eop = 0, rd_en = 0, ovf_clear = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_sop, rd_eop, rd_valid, burst_avail, pkt_avail, pause_req, ovf_flag;

  rx_pkt_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .MAX_PKT(DEPTH)) u_rx_pkt_fifo (
    .clk, .rst, .lo_thresh, .hi_thresh, .wr_en, .wr_data, .wr_sop, .wr_eop,
    .rd_en, .rd_data, .rd_sop, .rd_eop, .rd_valid, .burst_avail, .pkt_avail,
    .pause_req, .ovf_clear, .ovf_flag);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model
  logic [DW+1:0] q [16];
  int head = 0, tail = 0, mcount = 0, meop = 0;
  bit mpause = 0, movf = 0, mvalid = 0;
  logic [DW+1:0] mword = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check(rd_valid == mvalid, "R4 rd_valid", rd_valid, mvalid);
    if (mvalid) begin
      check(rd_data == mword[DW-1:0], "R4 rd_data", rd_data, mword[DW-1:0]);
      check({rd_sop, rd_eop} == mword[DW+1:DW], "R8 markers", {rd_sop, rd_eop}, mword[DW+1:DW]);
    end
    check(burst_avail == (mcount > int'(lo_thresh)), "R2 burst_avail", burst_avail, mcount > int'(lo_thresh));
    check(pkt_avail == (meop > 0), "R5 pkt_avail", pkt_avail, meop > 0);
    check(pause_req == mpause, "R6 pause_req", pause_req, mpause);
    check(ovf_flag == movf, "R7 ovf_flag", ovf_flag, movf);
  endtask

  task automatic do_reset(input int lo, input int hi);
    @(negedge clk);
    rst = 1; wr_en = 0; rd_en = 0; ovf_clear = 0;
    lo_thresh = (AW+1)'(lo); hi_thresh = (AW+1)'(hi);
    @(posedge clk); @(posedge clk); #1;
    head = 0; tail = 0; mcount = 0; meop = 0; mpause = 0; movf = 0; mvalid = 0;
    // R1 outputs low during reset
    check({rd_valid, burst_avail, pkt_avail, pause_req, ovf_flag} == 5'b0, "R1 reset outputs",
          {rd_valid, burst_avail, pkt_avail, pause_req, ovf_flag}, 0);
    @(negedge clk); rst = 0;
  endtask

  task automatic step(input bit w, input int d, input bit s, input bit e, input bit r, input bit clr);
    bit rd_ok, wr_ok;
    @(negedge clk);
    wr_en = w; wr_data = DW'(d); wr_sop = s; wr_eop = e; rd_en = r; ovf_clear = clr;
    @(posedge clk); #1;
    rd_ok = r && mcount > 0;
    wr_ok = w && mcount < DEPTH;
    mvalid = rd_ok;
    if (rd_ok) begin
      mword = q[head]; head = (head + 1) % 16;
      if (mword[DW]) meop--;
    end
    if (wr_ok) begin
      q[tail] = {s, e, DW'(d)}; tail = (tail + 1) % 16;
      if (e) meop++;
    end
    if (w && mcount == DEPTH) movf = 1;
    else if (clr) movf = 0;
    mcount = mcount + int'(wr_ok) - int'(rd_ok);
    if (mcount > int'(hi_thresh)) mpause = 1;
    else if (mcount <= int'(lo_thresh)) mpause = 0;
    check_all();
  endtask

  initial begin
    do_reset(0, 7);
    check_all();
    // R2 sweep: every low threshold against every fill level, then drain (R3 on last read)
    for (int lo = 0; lo < DEPTH; lo++) begin
      do_reset(lo, 7);
      for (int n = 1; n <= DEPTH; n++) step(1, n * 7 + lo, 0, 0, 0, 0);
      for (int n = 0; n <= DEPTH; n++) step(0, 0, 0, 0, 1, 0);
    end
    // R6 hysteresis, R7 overflow and clear, R3 reads while empty
    do_reset(2, 5);
    for (int n = 0; n < DEPTH + 2; n++) step(1, 100 + n, n == 0, n == 7, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    for (int n = 0; n < DEPTH + 3; n++) step(0, 0, 0, 0, 1, 0);
    check(rd_valid == 0, "R3 empty read valid", rd_valid, 0);
    // R5/R8 packet mix with simultaneous reads and writes
    do_reset(0, 6);
    for (int i = 0; i < 60; i++)
      step(i % 3 != 0, 200 - i, i % 4 == 0, i % 4 == 3, (i % 2 == 0) && i > 6, 0);
    for (int i = 0; i < 12; i++) step(i % 2 == 0, 50 + i, 1, 1, 1, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1, 0);
    // R1 reset in mid-traffic
    for (int i = 0; i < 5; i++) step(1, i, 0, 1, 0, 0);
    do_reset(1, 4);
    check_all();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule